// File: doc/BRIEF.md
# Shift-Add-XOR Pseudo-Random Sequence Generator

This block produces a WIDTH-bit pseudo-random sequence from a single state register. On every enabled clock the state is rotated left by one place, so the bit that leaves the top becomes a carry into bit zero. A programmable addend is then added modulo 2^WIDTH, and the sum is XORed with a programmable mask. The mapping is not linear over GF(2), so the block is not an LFSR. With a suitable pair of odd constants the sequence has period 2^WIDTH and passes through every value, zero included.

A seed can be loaded at any time, and a load takes priority over a step. The current state is presented on every cycle. A wrap flag pulses for one cycle whenever a step lands on zero. When the sequence is started from zero, that pulse marks the end of one full traversal.

Top module: `sax_prng`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `state_q` is all zeros and `wrap_pulse` is 0.
- R2: After a clock edge with `step_en`=1 and `seed_load`=0, `state_q` equals ((S shifted left one place) + S[WIDTH-1] + `add_k`) XOR `xor_k`, truncated to WIDTH bits. S, `add_k` and `xor_k` are the values present at that edge.
- R3: The top bit of the state goes back into bit 0 of the sum. For example, with WIDTH=16, S=0x8000 and both constants zero, the next state is 0x0001.
- R4: After an edge with `step_en`=0 and `seed_load`=0, `state_q` keeps its value and `wrap_pulse` is 0.
- R5: After an edge with `seed_load`=1, `state_q` equals `seed_val` whatever the value of `step_en`, and `wrap_pulse` is 0, even when the seed is zero.
- R6: `wrap_pulse` is 1 for exactly the cycle after a step whose result is zero, and is 0 in every other cycle.
- R7: With WIDTH=16, `add_k`=0x7F25 and `xor_k`=0x00DB, starting from zero, the first wrap pulse comes on step 65536. This means all 2^16 states are visited.
- R8: With WIDTH=16, `add_k`=0x778B and `xor_k`=0x4A8B, starting from zero, the first wrap pulse also comes on step 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the sequence by one step |
| seed_load | input | 1 | Replace the state with `seed_val`; overrides `step_en` |
| seed_val | input | WIDTH | Value loaded by `seed_load` |
| add_k | input | WIDTH | Constant added after the rotate |
| xor_k | input | WIDTH | Constant XORed into the sum |
| state_q | output | WIDTH | Current generator state |
| wrap_pulse | output | 1 | One-cycle flag marking a step that produced zero |

## Verification
On every cycle the assertions check four things: the one-step update rule (worked out independently as shift plus top-bit plus addend), that the state holds when idle, that a load puts the seed in place and clears the flag, and that the wrap flag only appears together with a zero state. Some behaviour needs a long run or a chosen stimulus, so only the bench scenarios can show it. These cases are the full 65536-step period for both constant pairs, the exact step on which the first wrap comes, and the top-bit carry value.

// File: rtl/sax_pkg.sv
// Shared definitions for the shift-add-xor generator.
// Assumes: used only by the sax_* modules.
package sax_pkg;

    // What the state register does on the next edge
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_STEP = 2'd1,
        UPD_LOAD = 2'd2
    } upd_kind_t;

endpackage

// File: rtl/sax_rotadd.sv
// Rotates the state left by one place and adds the addend constant.
// The rotate puts the old top bit into bit 0; bit 0 of a plain left shift
// is always zero, so this equals adding that bit as a carry-in.
// Assumes: WIDTH >= 2; the sum wraps modulo 2^WIDTH.
module sax_rotadd #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_val,
    input  logic [WIDTH-1:0] addend,
    output logic [WIDTH-1:0] sum_val
);

    logic [WIDTH-1:0] rotated;

    // Rotate left by one and add the addend, with the carry out dropped
    always_comb begin
        rotated = {cur_val[WIDTH-2:0], cur_val[WIDTH-1]};
        sum_val = rotated + addend;
    end

endmodule

// File: rtl/sax_xormix.sv
// Applies the XOR mask to the rotated sum, one bit per generate lane.
// Assumes: both inputs have the same width.
module sax_xormix #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] sum_val,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] mixed
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        // One XOR gate per bit lane
        assign mixed[b] = sum_val[b] ^ mask[b];
    end

endmodule

// File: rtl/sax_ctrl.sv
// Chooses the update kind: a load wins over a step, and otherwise the state holds.
// Assumes: inputs are synchronous to the generator clock.
module sax_ctrl
    import sax_pkg::*;
(
    input  logic      step_en,
    input  logic      seed_load,
    output upd_kind_t kind
);

    // Priority decode of the two strobes
    always_comb begin
        if (seed_load)    kind = UPD_LOAD;
        else if (step_en) kind = UPD_STEP;
        else              kind = UPD_HOLD;
    end

endmodule

// File: rtl/sax_state_reg.sv
// Holds the generator state and the registered wrap flag.
// The flag is set only when a step (not a load) produces an all-zero state.
// Assumes: synchronous active-low reset.
module sax_state_reg
    import sax_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_kind_t        kind,
    input  logic [WIDTH-1:0] step_val,
    input  logic [WIDTH-1:0] seed_val,
    output logic [WIDTH-1:0] state_q,
    output logic             wrap_q
);

    logic step_is_zero;

    // Detect a zero result on the step path
    always_comb step_is_zero = (step_val == '0);

    // State and wrap flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            unique case (kind)
                UPD_LOAD: begin
                    state_q <= seed_val;
                    wrap_q  <= 1'b0;
                end
                UPD_STEP: begin
                    state_q <= step_val;
                    wrap_q  <= step_is_zero;
                end
                default: begin
                    wrap_q  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sax_prng.sv
// Top of the shift-add-xor pseudo-random generator.
// next = (rotl1(state) + add_k) ^ xor_k when stepped; a seed load has priority.
// Assumes: the constants are held steady while a sequence runs.
module sax_prng
    import sax_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_val,
    input  logic [WIDTH-1:0] add_k,
    input  logic [WIDTH-1:0] xor_k,
    output logic [WIDTH-1:0] state_q,
    output logic             wrap_pulse
);

    upd_kind_t        kind;
    logic [WIDTH-1:0] sum_val;
    logic [WIDTH-1:0] step_val;

    sax_ctrl u_ctrl (
        .step_en   (step_en),
        .seed_load (seed_load),
        .kind      (kind)
    );

    sax_rotadd #(.WIDTH(WIDTH)) u_rotadd (
        .cur_val (state_q),
        .addend  (add_k),
        .sum_val (sum_val)
    );

    sax_xormix #(.WIDTH(WIDTH)) u_xormix (
        .sum_val (sum_val),
        .mask    (xor_k),
        .mixed   (step_val)
    );

    sax_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .step_val (step_val),
        .seed_val (seed_val),
        .state_q  (state_q),
        .wrap_q   (wrap_pulse)
    );

endmodule

// File: rtl/sax_prng_chk.sv
// Property checker for sax_prng, attached with bind.
// Assumes: rst_n is asserted at time zero.
module sax_prng_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_val,
    input logic [WIDTH-1:0] add_k,
    input logic [WIDTH-1:0] xor_k,
    input logic [WIDTH-1:0] state_q,
    input logic             wrap_pulse
);

    logic             rst_low_q;
    logic [WIDTH-1:0] shl_val;
    logic [WIDTH-1:0] top_bit;
    logic [WIDTH-1:0] exp_next;

    // Remember whether the previous edge was in reset
    always_ff @(posedge clk) rst_low_q <= !rst_n;

    // Shift-then-carry form of the update rule
    always_comb begin
        shl_val  = {state_q[WIDTH-2:0], 1'b0};
        top_bit  = {{(WIDTH-1){1'b0}}, state_q[WIDTH-1]};
        exp_next = (shl_val + top_bit + add_k) ^ xor_k;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_low_q |-> (state_q == '0 && !wrap_pulse));

    assert_step_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load) |=> (state_q == $past(exp_next)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !seed_load) |=> ($stable(state_q) && !wrap_pulse));

    assert_load_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (state_q == $past(seed_val) && !wrap_pulse));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (state_q == '0));

endmodule

bind sax_prng sax_prng_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .seed_load  (seed_load),
    .seed_val   (seed_val),
    .add_k      (add_k),
    .xor_k      (xor_k),
    .state_q    (state_q),
    .wrap_pulse (wrap_pulse)
);

// File: tb/sax_prng_test.sv
module sax_prng_test;

    localparam int W      = 16;
    localparam int PERIOD = 1 << W;
    localparam int MASK   = PERIOD - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic         seed_load = 1'b0;
    logic [W-1:0] seed_val = '0;
    logic [W-1:0] add_k = '0;
    logic [W-1:0] xor_k = '0;
    logic [W-1:0] state_q;
    logic         wrap_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int m_state = 0;
    bit m_wrap  = 1'b0;

    always #10 clk = ~clk;

    sax_prng #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_load(seed_load),
        .seed_val(seed_val), .add_k(add_k), .xor_k(xor_k),
        .state_q(state_q), .wrap_pulse(wrap_pulse)
    );

    // Behavioural reference model, built from the requirement text
    always @(posedge clk) begin
        int nxt;
        if (!rst_n) begin
            m_state <= 0; m_wrap <= 1'b0;
        end else if (seed_load) begin
            m_state <= int'(seed_val); m_wrap <= 1'b0;
        end else if (step_en) begin
            nxt = ((m_state * 2) + (m_state / (PERIOD / 2)) + int'(add_k)) % PERIOD;
            nxt = (nxt ^ int'(xor_k)) & MASK;
            m_state <= nxt; m_wrap <= (nxt == 0);
        end else begin
            m_wrap <= 1'b0;
        end
    end

    // Compare the design with the model on every cycle, away from the edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(state_q) != m_state || wrap_pulse != m_wrap) begin
                fails++;
                $display("FAIL model R2/R4/R5/R6: state=%h wrap=%b expected state=%h wrap=%b",
                         state_q, wrap_pulse, m_state[W-1:0], m_wrap);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run from zero with one constant pair and find the step of the first wrap
    task automatic run_period(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        int first = 0;
        @(negedge clk);
        seed_load = 1'b1; seed_val = '0; add_k = a; xor_k = b; step_en = 1'b0;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b1;
        for (int i = 1; i <= PERIOD; i++) begin
            @(negedge clk);
            if (wrap_pulse && first == 0) first = i;
        end
        step_en = 1'b0;
        check(first == PERIOD, {tag, " first wrap step"}, first, PERIOD);
        check(state_q == '0, {tag, " state after full period"}, int'(state_q), 0);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(state_q == '0 && !wrap_pulse, "R1 during reset", int'(state_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(state_q == '0 && !wrap_pulse, "R1 after reset", int'(state_q), 0);

        // R3: the top bit comes back in as a carry
        seed_load = 1'b1; seed_val = 16'h8000;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        check(state_q == 16'h0001, "R3 top-bit carry", int'(state_q), 16'h0001);

        // R2: one step with both constants nonzero
        seed_load = 1'b1; seed_val = 16'hC3A5; add_k = 16'h7F25; xor_k = 16'h00DB;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        // rotl(C3A5)=874B, +7F25=0670, ^00DB=06AB
        check(state_q == 16'h06AB, "R2 single step", int'(state_q), 16'h06AB);

        // R4: idle holds the state
        repeat (3) @(negedge clk);
        check(state_q == 16'h06AB && !wrap_pulse, "R4 idle hold", int'(state_q), 16'h06AB);

        // R5: a load wins over a step; loading zero raises no wrap
        seed_load = 1'b1; step_en = 1'b1; seed_val = 16'h5A5A;
        @(negedge clk);
        check(state_q == 16'h5A5A, "R5 load priority", int'(state_q), 16'h5A5A);
        seed_val = 16'h0000;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b0;
        check(state_q == '0 && !wrap_pulse, "R5 zero load no wrap", int'(wrap_pulse), 0);

        // R6: a step that lands on zero pulses wrap for one cycle
        seed_load = 1'b1; seed_val = 16'h1234; add_k = 16'h0001; xor_k = 16'h2469;
        @(negedge clk);
        seed_load = 1'b0; step_en = 1'b1;
        @(negedge clk);
        check(wrap_pulse && state_q == '0, "R6 wrap on zero", int'(wrap_pulse), 1);
        @(negedge clk);
        step_en = 1'b0;
        check(!wrap_pulse && state_q == 16'h2468, "R6 wrap lasts one cycle", int'(state_q), 16'h2468);

        run_period(16'h7F25, 16'h00DB, "R7");
        run_period(16'h778B, 16'h4A8B, "R8");

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule